// File: doc/BRIEF.md
# APM Command SMI Trigger

This block sits behind a byte-wide power-management command port. Every byte written there is sorted into one of two kinds. Two reserved codes are ACPI mode switches: one turns the SCI-enable flag on, the other turns it off. Neither of them ever reaches the system-management interrupt path. Every other code is a request for the SMM handler. It raises a sticky SMI request only when an enable bit is set in a small bank of four configuration bytes.

The configuration bank is written one byte at a time through an index and data port. It can be read back combinationally through a separate index. A strap input says whether an SMM handler exists. When the strap is low, the SMI control byte comes out of reset with its enable bit already set, which marks SMM as already initialised. The SMI request is a level. It stays high until the acknowledge input is pulsed.

Top module: `apm_smi_trigger`

## Requirements
- R1: A command write of 0xF1 sets `sci_en` on the next clock edge.
- R2: A command write of 0xF0 clears `sci_en` on the next clock edge.
- R3: A command write of 0xF0 or 0xF1 never raises `smi_req`, whatever the configuration bytes hold.
- R4: Any other command value raises `smi_req` on the next edge if, and only if, bit 1 of configuration byte index 3 (the SMI control byte) is 1.
- R5: After reset with `smm_present` high, configuration bytes at indices 0 to 3 all read 0x00.
- R6: After reset with `smm_present` low, byte index 3 reads 0x02, and bytes 0 to 2 read 0x00.
- R7: Once raised, `smi_req` stays high through idle cycles and through further command writes until `smi_ack` is pulsed; the edge after an acknowledge (with no new raising command) shows it low.
- R8: During and right after reset, `sci_en` and `smi_req` are both 0.
- R9: A mode-switch write and an acknowledge in the same cycle both take effect: `sci_en` follows the command and `smi_req` is cleared.
- R10: When a configuration write and a command write share a cycle, the SMI decision uses the control byte value from before that write; the new byte value is stored.
- R11: A raising command and an acknowledge in the same cycle leave `smi_req` high (the new request wins).
- R12: A configuration write stores `cfg_wdata` at index `cfg_waddr`, readable on `cfg_rdata` from the next cycle at index `cfg_raddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_present | input | 1 | Strap: high when an SMM handler exists |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_data | input | 8 | Command byte |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_waddr | input | 2 | Configuration byte write index (0 to 3) |
| cfg_wdata | input | 8 | Configuration byte write data |
| cfg_raddr | input | 2 | Configuration byte read index |
| cfg_rdata | output | 8 | Configuration byte read data |
| smi_ack | input | 1 | Acknowledge pulse, clears the SMI request |
| sci_en | output | 1 | ACPI SCI-enable flag |
| smi_req | output | 1 | Sticky SMI request level |

## Verification
Some checks hold on every cycle. The mode codes set or clear `sci_en`, never raise the SMI request, and leave an idle request sticky. A non-mode command with the control bit clear leaves an idle request low. The bench has to show the rest. That covers the reset values under both strap settings and the byte bank's storage and readback. It also covers how same-cycle collisions resolve: configuration write against command, and acknowledge against either kind of command.

// File: rtl/apm_smi_pkg.sv
package apm_smi_pkg;
  localparam logic [7:0] ACPI_ON_CODE  = 8'hF1;
  localparam logic [7:0] ACPI_OFF_CODE = 8'hF0;

  // True for either reserved ACPI mode-switch code.
  function automatic logic is_mode_code(input logic [7:0] d);
    return (d == ACPI_ON_CODE) || (d == ACPI_OFF_CODE);
  endfunction

  // Reset value of configuration byte idx.
  function automatic logic [7:0] cfg_reset_value(input int idx, input int ctl_idx,
                                                 input logic smm_here,
                                                 input logic [7:0] no_smm_val);
    if (idx == ctl_idx && !smm_here) return no_smm_val;
    return 8'h00;
  endfunction
endpackage

// File: rtl/apm_cfg_bank.sv
module apm_cfg_bank #(
  parameter int DATA_W   = 8,
  parameter int NBYTES   = 4,
  parameter int CTL_IDX  = 3,
  parameter logic [7:0] NO_SMM_VAL = 8'h02,
  localparam int AW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           smm_present,
  input  logic                           wr,
  input  logic [AW-1:0]                  waddr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NBYTES-1:0][DATA_W-1:0]  bytes_q
);
  import apm_smi_pkg::*;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        bytes_q[g] <= DATA_W'(cfg_reset_value(g, CTL_IDX, smm_present, NO_SMM_VAL));
      else if (wr && (waddr == AW'(g)))
        bytes_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode #(
  parameter int DATA_W = 8
) (
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              smi_enable,
  output logic              acpi_on,
  output logic              acpi_off,
  output logic              smi_fire
);
  import apm_smi_pkg::*;

  logic mode_hit;

  always_comb begin
    mode_hit = is_mode_code(8'(cmd_data));
    acpi_on  = cmd_wr && (8'(cmd_data) == ACPI_ON_CODE);
    acpi_off = cmd_wr && (8'(cmd_data) == ACPI_OFF_CODE);
    smi_fire = cmd_wr && !mode_hit && smi_enable;
  end

  // R3: a mode switch and an SMI raise never coincide
  always_comb begin
    a_r3_mode_excludes_smi: assert (!(smi_fire && (acpi_on || acpi_off)));
  end
endmodule

// File: rtl/apm_ctl_state.sv
module apm_ctl_state (
  input  logic clk,
  input  logic rst_n,
  input  logic acpi_on,
  input  logic acpi_off,
  input  logic smi_fire,
  input  logic smi_ack,
  output logic sci_en,
  output logic smi_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sci_en  <= 1'b0;
      smi_req <= 1'b0;
    end else begin
      if (acpi_on)       sci_en <= 1'b1;
      else if (acpi_off) sci_en <= 1'b0;
      if (smi_fire)      smi_req <= 1'b1;
      else if (smi_ack)  smi_req <= 1'b0;
    end
  end

  a_r1_sci_set: assert property (@(posedge clk) disable iff (!rst_n)
    acpi_on |=> sci_en);
  a_r2_sci_clear: assert property (@(posedge clk) disable iff (!rst_n)
    acpi_off |=> !sci_en);
  a_r7_smi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && !smi_ack) |=> smi_req);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_ack && !smi_fire) |=> !smi_req);
endmodule

// File: rtl/apm_smi_trigger.sv
module apm_smi_trigger #(
  parameter int DATA_W   = 8,
  parameter int NBYTES   = 4,
  parameter int CTL_IDX  = 3,
  parameter int SMI_EN_BIT = 1,
  parameter logic [7:0] NO_SMM_VAL = 8'h02,
  localparam int AW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smm_present,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_waddr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [AW-1:0]     cfg_raddr,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              smi_ack,
  output logic              sci_en,
  output logic              smi_req
);
  import apm_smi_pkg::*;

  logic [NBYTES-1:0][DATA_W-1:0] cfg_q;
  logic smi_enable, acpi_on, acpi_off, smi_fire;

  apm_cfg_bank #(.DATA_W(DATA_W), .NBYTES(NBYTES), .CTL_IDX(CTL_IDX),
                 .NO_SMM_VAL(NO_SMM_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .smm_present(smm_present),
    .wr(cfg_wr), .waddr(cfg_waddr), .wdata(cfg_wdata), .bytes_q(cfg_q));

  // Registered byte: a same-cycle write is seen only from the next cycle (R10).
  assign smi_enable = cfg_q[CTL_IDX][SMI_EN_BIT];
  assign cfg_rdata  = cfg_q[cfg_raddr];

  apm_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_wr(cmd_wr), .cmd_data(cmd_data), .smi_enable(smi_enable),
    .acpi_on(acpi_on), .acpi_off(acpi_off), .smi_fire(smi_fire));

  apm_ctl_state u_state (
    .clk(clk), .rst_n(rst_n), .acpi_on(acpi_on), .acpi_off(acpi_off),
    .smi_fire(smi_fire), .smi_ack(smi_ack), .sci_en(sci_en), .smi_req(smi_req));

  a_r3_mode_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && is_mode_code(8'(cmd_data)) && !smi_req) |=> !smi_req);
  a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cfg_q[CTL_IDX][SMI_EN_BIT] && !smi_req) |=> !smi_req);
endmodule

// File: tb/tb_apm_smi_trigger.sv
module tb_apm_smi_trigger;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, smm_present = 1'b1;
  logic cmd_wr = 1'b0, cfg_wr = 1'b0, smi_ack = 1'b0;
  logic [7:0] cmd_data = '0, cfg_wdata = '0, cfg_rdata;
  logic [1:0] cfg_waddr = '0, cfg_raddr = '0;
  logic sci_en, smi_req;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apm_smi_trigger dut (
    .clk(clk), .rst_n(rst_n), .smm_present(smm_present),
    .cmd_wr(cmd_wr), .cmd_data(cmd_data), .cfg_wr(cfg_wr),
    .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata), .smi_ack(smi_ack), .sci_en(sci_en), .smi_req(smi_req));

  // {cfg byte 3, command, expected smi_req, expected sci_en}; smi acked before each
  localparam logic [17:0] VEC [8] = '{
    {8'h02, 8'h55, 1'b1, 1'b0},
    {8'h00, 8'h55, 1'b0, 1'b0},
    {8'h02, 8'hF1, 1'b0, 1'b1},
    {8'hFF, 8'hF0, 1'b0, 1'b0},
    {8'hFF, 8'h00, 1'b1, 1'b0},
    {8'hFD, 8'hEF, 1'b0, 1'b0},
    {8'h02, 8'hF1, 1'b0, 1'b1},
    {8'h02, 8'hF2, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle with the given strobes; returns at the following negedge.
  task automatic cycle(input logic cw, input logic [7:0] cd, input logic fw,
                       input logic [1:0] fa, input logic [7:0] fd, input logic ak);
    cmd_wr = cw; cmd_data = cd; cfg_wr = fw; cfg_waddr = fa; cfg_wdata = fd; smi_ack = ak;
    @(negedge clk);
    cmd_wr = 0; cfg_wr = 0; smi_ack = 0;
  endtask

  task automatic do_reset(input logic strap);
    smm_present = strap; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset(1'b1);
    check("R8 sci_en", {7'd0, sci_en}, 8'h00);
    check("R8 smi_req", {7'd0, smi_req}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      cfg_raddr = 2'(i); #1;
      check("R5 cfg byte", cfg_rdata, 8'h00);
    end

    // Vector table: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      cycle(0, 8'h00, 1, 2'd3, VEC[i][17:10], 1);
      cycle(1, VEC[i][9:2], 0, 2'd0, 8'h00, 0);
      check("R4/R3 smi_req", {7'd0, smi_req}, {7'd0, VEC[i][1]});
      check("R1/R2 sci_en", {7'd0, sci_en}, {7'd0, VEC[i][0]});
    end

    // R12 store and read back
    cycle(0, 8'h00, 1, 2'd0, 8'hA5, 0);
    cycle(0, 8'h00, 1, 2'd1, 8'h3C, 0);
    cfg_raddr = 2'd0; #1; check("R12 byte0", cfg_rdata, 8'hA5);
    cfg_raddr = 2'd1; #1; check("R12 byte1", cfg_rdata, 8'h3C);

    // R6 strap low
    do_reset(1'b0);
    cfg_raddr = 2'd3; #1; check("R6 byte3", cfg_rdata, 8'h02);
    cfg_raddr = 2'd0; #1; check("R6 byte0", cfg_rdata, 8'h00);
    check("R8 sci_en after reset", {7'd0, sci_en}, 8'h00);

    // R7 sticky
    cycle(1, 8'h33, 0, 2'd0, 8'h00, 0);
    check("R6 smi from forced enable", {7'd0, smi_req}, 8'h01);
    cycle(0, 8'h00, 0, 2'd0, 8'h00, 0);
    cycle(0, 8'h00, 0, 2'd0, 8'h00, 0);
    check("R7 idle holds", {7'd0, smi_req}, 8'h01);
    cycle(1, 8'h44, 0, 2'd0, 8'h00, 0);
    check("R7 further cmd holds", {7'd0, smi_req}, 8'h01);
    cycle(1, 8'hF0, 0, 2'd0, 8'h00, 0);
    check("R7 mode cmd holds", {7'd0, smi_req}, 8'h01);
    cycle(0, 8'h00, 0, 2'd0, 8'h00, 1);
    check("R7 ack clears", {7'd0, smi_req}, 8'h00);

    // R9 mode write plus ack
    cycle(1, 8'h77, 0, 2'd0, 8'h00, 0);
    cycle(1, 8'hF1, 0, 2'd0, 8'h00, 1);
    check("R9 smi cleared", {7'd0, smi_req}, 8'h00);
    check("R9 sci set", {7'd0, sci_en}, 8'h01);

    // R11 raise plus ack
    cycle(1, 8'h66, 0, 2'd0, 8'h00, 1);
    check("R11 raise wins", {7'd0, smi_req}, 8'h01);
    cycle(0, 8'h00, 0, 2'd0, 8'h00, 1);

    // R10 old control byte decides
    cycle(0, 8'h00, 1, 2'd3, 8'h00, 0);
    cycle(1, 8'h55, 1, 2'd3, 8'h02, 0);
    check("R10 old clear value", {7'd0, smi_req}, 8'h00);
    cfg_raddr = 2'd3; #1; check("R10 new value stored", cfg_rdata, 8'h02);
    cycle(1, 8'h55, 1, 2'd3, 8'h00, 0);
    check("R10 old set value", {7'd0, smi_req}, 8'h01);
    cfg_raddr = 2'd3; #1; check("R10 cleared stored", cfg_rdata, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule